// File: doc/BRIEF.md
# Two-Class Round-Robin Bus Arbiter

This block shares one bus among a fixed set of requesters in a multicore system whose timing must be predictable. Each requester belongs to one of two classes, fixed by a parameter when the block is built: time-critical or best-effort. A time-critical request always wins over a best-effort request that is pending in the same cycle. Within each class, requests are served in rotating order. When the bus is idle, the block spends one cycle making its decision. It then holds the grant for a fixed number of transfer cycles, and nothing can cut a transfer short.

For worst-case timing analysis the block has a padding mode. When this mode is on, every time-critical access signals completion exactly at its analytical worst-case latency, whatever contention actually happened. The bound is taken from the class mask and the transfer length. With S = BUS_LAT + 1 as the length of one arbitration-plus-transfer slot, H as the number of time-critical requesters and B as the number of best-effort requesters, the bound is L = BUS_LAT + (H-1)*S + (B>0 ? S-1 : 0). Latency is counted from the first cycle a request is high to the cycle its completion pulse is high. With the defaults (four requesters, BUS_LAT = 2, requesters 0 and 2 time-critical) L = 7.

Top module: `rt_bus_arbiter`

## Requirements
- R1: At most one bit of grantVec is high in any cycle, and grantVec is non-zero exactly when busBusy is high.
- R2: When the bus is idle and at least one request is high, the grant appears in the next cycle and goes to a requester that was requesting. With no request pending, the bus stays idle.
- R3: A grant stays unchanged for exactly BUS_LAT consecutive cycles (default 2). After that the bus is idle for at least one cycle.
- R4: When the bus is idle and a time-critical request is pending (HARD_MASK bit set, default requesters 0 and 2), a time-critical requester is granted, even if a best-effort request is pending in the same cycle.
- R5: Time-critical requesters are served in rotating order. After reset the search starts at requester 0. After a time-critical grant to requester k, the search starts at k+1, wrapping to 0. A best-effort grant does not move this position.
- R6: Best-effort requesters are served only when no time-critical request is pending. They follow their own rotating order, which starts at requester 0 after reset and moves past each best-effort requester that is granted.
- R7: A transfer that has started is never preempted. A time-critical request that arrives one cycle after a best-effort grant is granted only after that transfer and one arbitration cycle, so its first grant cycle comes 3 cycles after its request.
- R8: With padMode low, doneVec[k] is high in the last grant cycle of requester k's transfer, so an uncontended access has latency BUS_LAT.
- R9: With padMode low, no time-critical access has latency above L (default 7).
- R10: With padMode high, every time-critical access has latency exactly L, and the bus is released after the transfer while the completion is delayed. Best-effort accesses keep the timing of R8.
- R11: During and right after reset, no grant, busy or done output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_REQ | Per-requester request, held until granted |
| padMode | input | 1 | Worst-case padding of time-critical completions; changed only while idle |
| grantVec | output | NUM_REQ | One-hot bus grant, held for the transfer |
| busBusy | output | 1 | A transfer occupies the bus |
| doneVec | output | NUM_REQ | One-cycle completion pulse per requester |

## Verification
The bench drives single requests, all requesters at once, pairs within one class, and a mix of classes in the same cycle. From these it can tell whether the class priority holds and whether each class keeps its own rotation. Other patterns stagger a request by one cycle behind a best-effort grant, either for one requester or for two time-critical ones. These show that a transfer is not preempted and that the worst case reaches the bound exactly. The same patterns run again with padding on, which separates a fixed completion latency from the latency that contention actually produced.

// File: rtl/busArbPkg.sv
package busArbPkg;

  typedef enum logic {
    ST_IDLE,
    ST_XFER
  } arbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // arbitration decision taken this cycle
    logic busy;  // transfer cycle
    logic last;  // final transfer cycle
  } arbStrobe_t;

  function automatic int countBits(input logic [31:0] m, input int width);
    int n;
    n = 0;
    for (int k = 0; k < width; k++) begin
      if (m[k]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/rt_arb_ctrl.sv
module rt_arb_ctrl
  import busArbPkg::*;
#(
  parameter int BUS_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  output arbStrobe_t strobes
);

  localparam int CNT_W = (BUS_LAT > 1) ? $clog2(BUS_LAT) : 1;

  arbState_e        state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (anyReq) begin
            state <= ST_XFER;
            cnt   <= CNT_W'(BUS_LAT - 1);
          end
        end
        default: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.load = (state == ST_IDLE) && anyReq;
    strobes.busy = (state == ST_XFER);
    strobes.last = (state == ST_XFER) && (cnt == '0);
  end

endmodule

// File: rtl/rt_arb_datapath.sv
module rt_arb_datapath
  import busArbPkg::*;
#(
  parameter int                 NUM_REQ   = 4,
  parameter int                 BUS_LAT   = 2,
  parameter logic [NUM_REQ-1:0] HARD_MASK = 4'b0101
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic               padMode,
  input  arbStrobe_t         strobes,
  output logic [NUM_REQ-1:0] grantVec,
  output logic [NUM_REQ-1:0] doneVec
);

  localparam int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int SLOT    = BUS_LAT + 1;
  localparam int NUM_HRD = countBits(32'(HARD_MASK), NUM_REQ);
  localparam int NUM_SFT = NUM_REQ - NUM_HRD;
  localparam int UBD     = ((NUM_HRD > 0) ? (NUM_HRD - 1) : 0) * SLOT
                         + ((NUM_SFT > 0) ? (SLOT - 1) : 0);
  localparam int LBOUND  = BUS_LAT + UBD;
  localparam int AGE_W   = $clog2(LBOUND + 1) + 1;

  logic [NUM_REQ-1:0] hardReq, softReq;
  logic [IDX_W-1:0]   hardPtr, softPtr, owner, pick, pickNext;
  logic               pickHard;

  // first set bit of m at or after position p, wrapping
  function automatic logic [IDX_W-1:0] rrPick(input logic [NUM_REQ-1:0] m,
                                               input logic [IDX_W-1:0]   p);
    logic [IDX_W-1:0] sel;
    int               idx;
    sel = p;
    for (int k = NUM_REQ - 1; k >= 0; k--) begin
      idx = int'(p) + k;
      if (idx >= NUM_REQ) idx = idx - NUM_REQ;
      if (m[idx]) sel = IDX_W'(idx);
    end
    return sel;
  endfunction

  always_comb begin
    hardReq  = reqVec & HARD_MASK;
    softReq  = reqVec & ~HARD_MASK;
    pickHard = |hardReq;
    pick     = pickHard ? rrPick(hardReq, hardPtr) : rrPick(softReq, softPtr);
    pickNext = (int'(pick) == NUM_REQ - 1) ? '0 : pick + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner   <= '0;
      hardPtr <= '0;
      softPtr <= '0;
    end else if (strobes.load) begin
      owner <= pick;
      if (pickHard) hardPtr <= pickNext;
      else          softPtr <= pickNext;
    end
  end

  assign grantVec = strobes.busy ? (NUM_REQ'(1) << owner) : '0;

  // per-requester age tracking and completion
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    logic             active, ended, ownLast, padOn;
    logic [AGE_W-1:0] age, curAge;

    assign ownLast    = strobes.last && (owner == IDX_W'(i));
    assign padOn      = padMode && HARD_MASK[i];
    assign curAge     = active ? age : '0;
    assign doneVec[i] = padOn ? (active && (ended || ownLast) && (curAge == AGE_W'(LBOUND)))
                              : ownLast;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        active <= 1'b0;
        ended  <= 1'b0;
        age    <= '0;
      end else if (doneVec[i]) begin
        active <= 1'b0;
        ended  <= 1'b0;
      end else begin
        if (!active && reqVec[i]) begin
          active <= 1'b1;
          age    <= AGE_W'(1);
        end else if (active) begin
          age <= age + 1'b1;
        end
        if (ownLast) ended <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rt_bus_arbiter.sv
module rt_bus_arbiter
  import busArbPkg::*;
#(
  parameter int                 NUM_REQ   = 4,
  parameter int                 BUS_LAT   = 2,
  parameter logic [NUM_REQ-1:0] HARD_MASK = 4'b0101
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqVec,
  input  logic               padMode,
  output logic [NUM_REQ-1:0] grantVec,
  output logic               busBusy,
  output logic [NUM_REQ-1:0] doneVec
);

  arbStrobe_t strobes;

  rt_arb_ctrl #(.BUS_LAT(BUS_LAT)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .anyReq (|reqVec),
    .strobes(strobes)
  );

  rt_arb_datapath #(
    .NUM_REQ  (NUM_REQ),
    .BUS_LAT  (BUS_LAT),
    .HARD_MASK(HARD_MASK)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqVec  (reqVec),
    .padMode (padMode),
    .strobes (strobes),
    .grantVec(grantVec),
    .doneVec (doneVec)
  );

  assign busBusy = strobes.busy;

endmodule

// File: rtl/rt_bus_arbiter_chk.sv
module rt_bus_arbiter_chk #(
  parameter int                 NUM_REQ   = 4,
  parameter int                 BUS_LAT   = 2,
  parameter logic [NUM_REQ-1:0] HARD_MASK = 4'b0101
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqVec,
  input logic               padMode,
  input logic [NUM_REQ-1:0] grantVec,
  input logic               busBusy,
  input logic [NUM_REQ-1:0] doneVec
);

  localparam int RUN_W = $clog2(BUS_LAT + 2) + 1;

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)        runLen <= '0;
    else if (busBusy) runLen <= runLen + 1'b1;
    else              runLen <= '0;
  end

  p_one_grant_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantVec != '0) == busBusy));

  p_arb_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && (reqVec != '0)) |=> (busBusy && ((grantVec & $past(reqVec)) != '0)));

  p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && (reqVec == '0)) |=> !busBusy);

  p_hold_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && $past(busBusy)) |-> (grantVec == $past(grantVec)));

  p_xfer_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && $past(busBusy)) |-> (int'(runLen) == BUS_LAT));

  p_xfer_max_r3: assert property (@(posedge clk) disable iff (!rstN)
    busBusy |-> (int'(runLen) < BUS_LAT));

  p_hard_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busBusy && ((reqVec & HARD_MASK) != '0)) |=> ((grantVec & HARD_MASK) != '0));

  p_done_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!padMode && (doneVec != '0)) |-> (doneVec == grantVec));

endmodule

bind rt_bus_arbiter rt_bus_arbiter_chk #(
  .NUM_REQ  (NUM_REQ),
  .BUS_LAT  (BUS_LAT),
  .HARD_MASK(HARD_MASK)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqVec  (reqVec),
  .padMode (padMode),
  .grantVec(grantVec),
  .busBusy (busBusy),
  .doneVec (doneVec)
);

// File: tb/rt_bus_arbiter_test.sv
module rt_bus_arbiter_test;

  localparam int N     = 4;
  localparam int BL    = 2;
  localparam logic [N-1:0] HM = 4'b0101;
  localparam int NH    = 2;
  localparam int NS    = 2;
  localparam int LB    = BL + (NH - 1) * (BL + 1) + ((NS > 0) ? BL : 0);

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqVec = '0;
  logic         padMode = 1'b0;
  logic [N-1:0] grantVec;
  logic         busBusy;
  logic [N-1:0] doneVec;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int startCyc [N];
  int lastLat [N];
  logic [N-1:0] outstanding = '0;
  logic prevBusy = 1'b0;
  logic finished = 1'b0;
  int sb[$];

  rt_bus_arbiter #(.NUM_REQ(N), .BUS_LAT(BL), .HARD_MASK(HM)) uut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .padMode(padMode),
    .grantVec(grantVec), .busBusy(busBusy), .doneVec(doneVec)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  // driver: raise requests and push the expected grant order
  task automatic raise(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        reqVec[i]      = 1'b1;
        startCyc[i]    = cyc;
        outstanding[i] = 1'b1;
      end
    end
  endtask

  task automatic expect_order(input int a, input int b, input int c, input int d);
    if (a >= 0) sb.push_back(a);
    if (b >= 0) sb.push_back(b);
    if (c >= 0) sb.push_back(c);
    if (d >= 0) sb.push_back(d);
  endtask

  task automatic wait_all;
    while (outstanding != '0) tick(1);
    tick(2);
  endtask

  // monitor: compare grants against the scoreboard and measure latency
  always @(negedge clk) begin
    if (rstN) begin
      if (grantVec != '0 && !prevBusy) begin
        int gid;
        int exp;
        gid = -1;
        for (int i = 0; i < N; i++) if (grantVec[i]) gid = i;
        check($countones(grantVec) == 1, "R1", "grant one-hot count", $countones(grantVec), 1);
        if (sb.size() == 0) begin
          check(1'b0, "R5/R6", "unexpected grant id", gid, -1);
        end else begin
          exp = sb.pop_front();
          check(gid == exp, "R4 R5 R6", "grant order id", gid, exp);
        end
      end
      reqVec = reqVec & ~grantVec;
      for (int i = 0; i < N; i++) begin
        if (doneVec[i] && outstanding[i]) begin
          lastLat[i]     = cyc - startCyc[i];
          outstanding[i] = 1'b0;
          if (HM[i] && padMode)
            check(lastLat[i] == LB, "R10", "padded hard latency", lastLat[i], LB);
          else if (HM[i])
            check(lastLat[i] <= LB, "R9", "hard latency within bound", lastLat[i], LB);
        end
      end
      prevBusy = busBusy;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check(grantVec == '0, "R11", "grant in reset", int'(grantVec), 0);
    check(!busBusy, "R11", "busy in reset", int'(busBusy), 0);
    check(doneVec == '0, "R11", "done in reset", int'(doneVec), 0);
    @(posedge clk); #2;
    rstN = 1'b1;
    tick(1);
    @(negedge clk);
    check(grantVec == '0 && !busBusy && doneVec == '0, "R11", "idle after reset",
          int'(busBusy), 0);
    tick(1);

    // R4 R5 R6: all four at once, pointers at 0
    expect_order(0, 2, 1, 3);
    raise(4'b1111);
    wait_all();
    check(lastLat[0] == BL, "R8", "first hard latency", lastLat[0], BL);
    check(lastLat[2] == 5, "R3", "second hard latency", lastLat[2], 5);
    check(lastLat[3] == 11, "R6", "last soft latency", lastLat[3], 11);

    // R2 R8: lone hard request
    expect_order(0, -1, -1, -1);
    raise(4'b0001);
    wait_all();
    check(lastLat[0] == BL, "R8", "uncontended latency", lastLat[0], BL);

    // lone soft request, then R5: hard pointer unaffected by soft grant
    expect_order(1, -1, -1, -1);
    raise(4'b0010);
    wait_all();
    expect_order(2, 0, -1, -1);
    raise(4'b0101);
    wait_all();

    // R6: soft rotation
    expect_order(3, 1, -1, -1);
    raise(4'b1010);
    wait_all();

    // R7: hard arrives one cycle after soft grant
    expect_order(3, 0, -1, -1);
    raise(4'b1000);
    tick(1);
    raise(4'b0001);
    wait_all();
    check(lastLat[0] == 4, "R7", "no preemption latency", lastLat[0], 4);

    // R9: worst case reaches the bound
    expect_order(1, 2, 0, -1);
    raise(4'b0010);
    tick(1);
    raise(4'b0101);
    wait_all();
    check(lastLat[0] == LB, "R9", "worst-case latency", lastLat[0], LB);

    // R4: mixed classes same cycle
    expect_order(2, 3, -1, -1);
    raise(4'b1100);
    wait_all();
    check(lastLat[3] == 5, "R4", "soft after hard latency", lastLat[3], 5);

    // R10: padding mode
    padMode = 1'b1;
    tick(1);
    expect_order(0, 2, 1, 3);
    raise(4'b1111);
    wait_all();
    check(lastLat[1] == 8, "R10", "soft latency with padding", lastLat[1], 8);
    expect_order(2, -1, -1, -1);
    raise(4'b0100);
    wait_all();
    check(lastLat[2] == LB, "R10", "padded lone hard", lastLat[2], LB);
    expect_order(1, -1, -1, -1);
    raise(4'b0010);
    wait_all();
    check(lastLat[1] == BL, "R10", "soft unpadded", lastLat[1], BL);
    padMode = 1'b0;
    tick(2);

    check(sb.size() == 0, "R2", "expected grants left", sb.size(), 0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule